// File: doc/BRIEF.md
# HyperRAM Row-Pair Refresh Sequencer

This block keeps a HyperRAM array refreshed under logic control. It issues short dummy read transactions in memory space with linear burst. Each one starts on the final word of a row and runs on into the first word of the next row, so a single chip-select cycle restores two rows. The block drives chip select, the clock and the 8-bit DQ bus during the command-address phase. It samples RWDS so that it can pick single or doubled initial latency. The data words the device returns are ignored.

A row pointer walks a programmable range in steps of two and wraps to the range start after the range end. A one-cycle done pulse marks each full pass over the range. New transactions start only while the external enable window is open, for example during video flyback. A transaction already in progress always runs to completion and releases chip select cleanly.

Top module: `hyperram_refresh_seq`

## Requirements
- R1: While reset is asserted and right after it, `cs_n` is 1, `ck` is 0, `dq_oe` is 0 and `done` is 0.
- R2: Each transaction drives six command-address bytes on `dq_out`, most significant byte first, one per CK edge, starting at the first rising edge. The 48-bit word holds bits [47:45]=3'b101 (read, memory space, linear burst), then the word address bits [31:3] in [44:16], zeros in [15:3], and word address bits [2:0] in [2:0]. The word address is (P+1)*ROW_WORDS-1, where P is the current row pointer.
- R3: In fixed mode (`var_lat`=0) every transaction has 6+4*LAT_CNT CK edges, whatever RWDS does. CK starts and ends low, and stays low whenever `cs_n` is high.
- R4: In variable mode (`var_lat`=1), RWDS is sampled at the edge that carries CA[23:16]. Low gives 6+2*LAT_CNT edges. High gives 6+4*LAT_CNT edges. Latency is counted from the CK cycle that holds CA[23:16], and data occupies the last four edges.
- R5: The row pointer starts at ROW_FIRST and advances by two after each transaction. When the next value would exceed ROW_LAST, it returns to ROW_FIRST.
- R6: `done` is a single-cycle pulse, raised as `cs_n` rises on the transaction that wraps the pointer.
- R7: While `win_en` is low, no transaction starts and `cs_n` stays high.
- R8: If `win_en` drops during a transaction, the transaction still completes with its full edge count.
- R9: Between transactions `cs_n` stays high for at least TRWR_TICKS*CK_DIV clock cycles.
- R10: `dq_oe` is high on exactly the six command-address edges and low on the latency and data edges. `dq_out` never changes in a cycle where CK toggles.
- R11: CK edges inside a transaction are spaced 2*CK_DIV clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_en | input | 1 | Refresh window; new transactions start only while high |
| var_lat | input | 1 | 0: fixed doubled latency, 1: latency chosen from RWDS |
| rwds | input | 1 | RWDS from the device, sampled during command-address |
| cs_n | output | 1 | Device chip select, active low |
| ck | output | 1 | Device clock |
| dq_out | output | 8 | DQ value driven during command-address |
| dq_oe | output | 1 | DQ output enable |
| done | output | 1 | Pulse at the end of each full pass over the row range |

## Verification
The bench builds the block with LAT_CNT=3, CK_DIV=2, ROW_WORDS=8 and a range of rows 4 to 9. A full pass is then three transactions, so wrap-around and the done pulse come up within the first handful of transactions. It decodes every command-address byte and counts every CK edge, so it can tell 12-edge transactions from 18-edge ones. It covers fixed mode with RWDS held low, both RWDS levels in variable mode, a closed window and a window that drops mid-transaction.

// File: rtl/hrr_pkg.sv
package hrr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } hrr_state_e;

    localparam int CA_BYTES = 6;

    // read, memory space, linear burst
    localparam logic [2:0] CA_CMD_RD_MEM_LIN = 3'b101;

    function automatic logic [47:0] build_ca(input logic [31:0] waddr);
        return {CA_CMD_RD_MEM_LIN, waddr[31:3], 13'd0, waddr[2:0]};
    endfunction

endpackage

// File: rtl/hrr_tick_gen.sv
module hrr_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = (cnt_q == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/hrr_row_walker.sv
module hrr_row_walker #(
    parameter int ROW_W     = 13,
    parameter int ROW_FIRST = 0,
    parameter int ROW_LAST  = 8191
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row,
    output logic             done
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             done;
    } walk_t;

    walk_t       w_d, w_q;
    logic [ROW_W:0] nxt;

    always_comb begin
        w_d      = w_q;
        w_d.done = 1'b0;
        nxt      = {1'b0, w_q.row} + (ROW_W+1)'(2);
        if (step) begin
            if (nxt > (ROW_W+1)'(ROW_LAST)) begin
                w_d.row  = ROW_W'(ROW_FIRST);
                w_d.done = 1'b1;
            end else begin
                w_d.row  = nxt[ROW_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.row  <= ROW_W'(ROW_FIRST);
            w_q.done <= 1'b0;
        end else begin
            w_q <= w_d;
        end
    end

    assign row  = w_q.row;
    assign done = w_q.done;

    // R5: pointer never leaves the programmed range
    p_row_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.row >= ROW_W'(ROW_FIRST)) && (w_q.row <= ROW_W'(ROW_LAST)));

    // R6: done lasts one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.done |=> !w_q.done);
endmodule

// File: rtl/hrr_ca_mux.sv
module hrr_ca_mux #(
    parameter int ROW_W     = 13,
    parameter int ROW_WORDS = 512
) (
    input  logic [ROW_W-1:0] row,
    input  logic [2:0]       idx,
    output logic [7:0]       ca_byte
);
    logic [31:0] waddr;
    logic [47:0] ca;

    always_comb begin
        // last word of row P, so the burst crosses into row P+1
        waddr = (32'(row) + 32'd1) * 32'(ROW_WORDS) - 32'd1;
        ca    = hrr_pkg::build_ca(waddr);
        unique case (idx)
            3'd0:    ca_byte = ca[47:40];
            3'd1:    ca_byte = ca[39:32];
            3'd2:    ca_byte = ca[31:24];
            3'd3:    ca_byte = ca[23:16];
            3'd4:    ca_byte = ca[15:8];
            3'd5:    ca_byte = ca[7:0];
            default: ca_byte = 8'd0;
        endcase
    end
endmodule

// File: rtl/hyperram_refresh_seq.sv
module hyperram_refresh_seq #(
    parameter int LAT_CNT    = 6,
    parameter int CK_DIV     = 2,
    parameter int ROW_WORDS  = 512,
    parameter int ROW_W      = 13,
    parameter int ROW_FIRST  = 0,
    parameter int ROW_LAST   = 8191,
    parameter int TRWR_TICKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       win_en,
    input  logic       var_lat,
    input  logic       rwds,
    output logic       cs_n,
    output logic       ck,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    output logic       done
);
    import hrr_pkg::*;

    localparam int EDGE_LONG  = CA_BYTES + 4 * LAT_CNT;
    localparam int EDGE_SHORT = CA_BYTES + 2 * LAT_CNT;
    localparam int EDGE_W     = $clog2(EDGE_LONG + 1);
    localparam int REC_W      = $clog2(TRWR_TICKS + 1);
    localparam int PIVOT_EDGE = 3;
    localparam int GAP_MIN    = TRWR_TICKS * CK_DIV;
    localparam int GAP_W      = $clog2(GAP_MIN + 1);

    typedef struct packed {
        hrr_state_e        st;
        logic              cs_n;
        logic              ck;
        logic [7:0]        dq;
        logic              oe;
        logic              phase;
        logic [EDGE_W-1:0] edges;
        logic              var_m;
        logic              dbl;
        logic [REC_W-1:0]  rec;
    } seq_t;

    seq_t              s_d, s_q;
    logic              tick;
    logic              step;
    logic [ROW_W-1:0]  row;
    logic [7:0]        ca_byte;
    logic [2:0]        ca_idx;
    logic [EDGE_W-1:0] n_edges;

    hrr_tick_gen #(.DIV(CK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    hrr_row_walker #(
        .ROW_W    (ROW_W),
        .ROW_FIRST(ROW_FIRST),
        .ROW_LAST (ROW_LAST)
    ) u_walk (
        .clk  (clk),
        .rst_n(rst_n),
        .step (step),
        .row  (row),
        .done (done)
    );

    assign ca_idx = (s_q.edges < EDGE_W'(CA_BYTES)) ? s_q.edges[2:0] : 3'd0;

    hrr_ca_mux #(.ROW_W(ROW_W), .ROW_WORDS(ROW_WORDS)) u_ca (
        .row    (row),
        .idx    (ca_idx),
        .ca_byte(ca_byte)
    );

    assign n_edges = s_q.dbl ? EDGE_W'(EDGE_LONG) : EDGE_W'(EDGE_SHORT);

    always_comb begin
        s_d  = s_q;
        step = 1'b0;
        if (tick) begin
            unique case (s_q.st)
                ST_IDLE: begin
                    if (win_en) begin
                        s_d.st    = ST_RUN;
                        s_d.cs_n  = 1'b0;
                        s_d.oe    = 1'b1;
                        s_d.dq    = ca_byte;
                        s_d.edges = '0;
                        s_d.phase = 1'b1;
                        s_d.var_m = var_lat;
                        s_d.dbl   = ~var_lat;
                    end
                end
                ST_RUN: begin
                    if (s_q.phase) begin
                        // edge tick: DQ was set one tick earlier
                        s_d.ck    = ~s_q.ck;
                        s_d.edges = s_q.edges + 1'b1;
                        s_d.phase = 1'b0;
                        if (s_q.var_m && (s_q.edges == EDGE_W'(PIVOT_EDGE)))
                            s_d.dbl = rwds;
                    end else if (s_q.edges == n_edges) begin
                        s_d.st    = ST_HOLD;
                        s_d.cs_n  = 1'b1;
                        s_d.oe    = 1'b0;
                        s_d.dq    = 8'd0;
                        s_d.edges = '0;
                        s_d.rec   = REC_W'(TRWR_TICKS - 1);
                        step      = 1'b1;
                    end else begin
                        s_d.phase = 1'b1;
                        if (s_q.edges < EDGE_W'(CA_BYTES)) begin
                            s_d.dq = ca_byte;
                            s_d.oe = 1'b1;
                        end else begin
                            s_d.dq = 8'd0;
                            s_d.oe = 1'b0;
                        end
                    end
                end
                ST_HOLD: begin
                    if (s_q.rec == '0) s_d.st  = ST_IDLE;
                    else               s_d.rec = s_q.rec - 1'b1;
                end
                default: s_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.cs_n  <= 1'b1;
            s_q.ck    <= 1'b0;
            s_q.dq    <= 8'd0;
            s_q.oe    <= 1'b0;
            s_q.phase <= 1'b0;
            s_q.edges <= '0;
            s_q.var_m <= 1'b0;
            s_q.dbl   <= 1'b1;
            s_q.rec   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_n   = s_q.cs_n;
    assign ck     = s_q.ck;
    assign dq_out = s_q.dq;
    assign dq_oe  = s_q.oe;

    // high-time counter for the recovery check
    logic [GAP_W-1:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              gap_q <= GAP_W'(GAP_MIN);
        else if (!s_q.cs_n)      gap_q <= '0;
        else if (gap_q != GAP_W'(GAP_MIN)) gap_q <= gap_q + 1'b1;
    end

    // R9: chip select high long enough before each new transaction
    p_cs_recovery_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (gap_q == GAP_W'(GAP_MIN)));

    // R3: clock parked low outside a transaction
    p_ck_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !ck);

    // R10: DQ driven only under chip select
    p_oe_in_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !cs_n);

    // R10: DQ stable on every CK edge
    p_dq_stable_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ck != $past(ck)) |-> (dq_out == $past(dq_out)));
endmodule

// File: tb/tb_hyperram_refresh_seq.sv
`timescale 1ns/100ps
module tb_hyperram_refresh_seq;
    localparam int LAT   = 3;
    localparam int DIV   = 2;
    localparam int RW    = 8;
    localparam int FIRST = 4;
    localparam int LAST  = 9;
    localparam int TRWR  = 3;
    localparam int E_LONG  = 6 + 4 * LAT;
    localparam int E_SHORT = 6 + 2 * LAT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic win_en = 1'b0;
    logic var_lat = 1'b0;
    logic rwds = 1'b0;
    logic cs_n, ck, dq_oe, done;
    logic [7:0] dq_out;

    always #2.5 clk = ~clk;

    hyperram_refresh_seq #(
        .LAT_CNT(LAT), .CK_DIV(DIV), .ROW_WORDS(RW), .ROW_W(13),
        .ROW_FIRST(FIRST), .ROW_LAST(LAST), .TRWR_TICKS(TRWR)
    ) dut (
        .clk(clk), .rst_n(rst_n), .win_en(win_en), .var_lat(var_lat),
        .rwds(rwds), .cs_n(cs_n), .ck(ck), .dq_out(dq_out),
        .dq_oe(dq_oe), .done(done)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_ca(input int r);
        logic [31:0] wa;
        wa = 32'((r + 1) * RW - 1);
        return {3'b101, wa[31:3], 13'd0, wa[2:0]};
    endfunction

    // ---------------- monitor ----------------
    int cyc = 0, txn_cnt = 0, edge_n = 0, last_tog = 0, cs_rise_cyc = 0;
    logic [47:0] ca_acc;
    bit oe_bad, dq_bad, per_bad, done_wide;
    logic prev_ck = 1'b0, prev_cs = 1'b1, prev_done = 1'b0;
    logic [7:0] prev_dq = 8'd0;
    logic [47:0] rec_ca [16];
    int rec_edges [16];
    int rec_gap [16];
    bit rec_oe_bad [16], rec_dq_bad [16], rec_per_bad [16], rec_ck_bad [16];
    int done_at [4];
    int done_n = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                edge_n = 0; ca_acc = '0;
                oe_bad = 0; dq_bad = 0; per_bad = 0;
                if (txn_cnt < 16) rec_gap[txn_cnt] = cyc - cs_rise_cyc;
            end
            if (!cs_n && ck != prev_ck) begin
                if (edge_n > 0 && (cyc - last_tog) != 2 * DIV) per_bad = 1;
                last_tog = cyc;
                if (dq_out != prev_dq) dq_bad = 1;
                if (edge_n < 6) begin
                    ca_acc = {ca_acc[39:0], dq_out};
                    if (!dq_oe) oe_bad = 1;
                end else if (dq_oe) oe_bad = 1;
                edge_n++;
            end
            if (!prev_cs && cs_n) begin
                if (txn_cnt < 16) begin
                    rec_ca[txn_cnt] = ca_acc;
                    rec_edges[txn_cnt] = edge_n;
                    rec_oe_bad[txn_cnt] = oe_bad;
                    rec_dq_bad[txn_cnt] = dq_bad;
                    rec_per_bad[txn_cnt] = per_bad;
                    rec_ck_bad[txn_cnt] = ck;
                end
                txn_cnt++;
                cs_rise_cyc = cyc;
            end
            if (done) begin
                if (prev_done) done_wide = 1;
                if (done_n < 4) done_at[done_n] = txn_cnt;
                done_n++;
            end
        end
        prev_ck = ck; prev_cs = cs_n; prev_dq = dq_out; prev_done = done;
    end

    task automatic wait_txn(input int n);
        while (txn_cnt < n) @(negedge clk);
    endtask

    task automatic check_txn(input int i, input int row, input int edges,
                             input string req);
        check(rec_ca[i] == exp_ca(row), "R2", $sformatf("CA of txn %0d", i),
              longint'(rec_ca[i]), longint'(exp_ca(row)));
        check(rec_edges[i] == edges, req, $sformatf("edge count txn %0d", i),
              rec_edges[i], edges);
        check(!rec_ck_bad[i], "R3", "ck low at cs_n rise", rec_ck_bad[i], 0);
        check(!rec_oe_bad[i] && !rec_dq_bad[i], "R10", "oe window / dq stability",
              {rec_oe_bad[i], rec_dq_bad[i]}, 0);
        check(!rec_per_bad[i], "R11", "ck edge spacing", rec_per_bad[i], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cs_n && !ck && !dq_oe && !done, "R1", "outputs in reset",
              {cs_n, ck, dq_oe, done}, 4'b1000);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(cs_n && !ck && !dq_oe && !done, "R1", "outputs after reset",
              {cs_n, ck, dq_oe, done}, 4'b1000);

        // fixed mode, RWDS low must not shorten latency (R3), rows walk (R5)
        var_lat = 1'b0; rwds = 1'b0; win_en = 1'b1;
        wait_txn(4);
        win_en = 1'b0;
        check_txn(0, 4, E_LONG, "R3");
        check_txn(1, 6, E_LONG, "R3");
        check_txn(2, 8, E_LONG, "R5");
        check_txn(3, 4, E_LONG, "R5");
        for (int i = 1; i < 4; i++)
            check(rec_gap[i] >= TRWR * DIV, "R9", "cs_n high time",
                  rec_gap[i], TRWR * DIV);
        check(done_n == 1 && done_at[0] == 3, "R6", "done after pass 1",
              done_at[0], 3);

        // closed window: nothing starts (R7)
        repeat (200) @(negedge clk);
        check(txn_cnt == 4 && cs_n, "R7", "no txn while window closed",
              txn_cnt, 4);

        // variable mode, RWDS low; window drops mid-transaction (R4, R8)
        var_lat = 1'b1; rwds = 1'b0; win_en = 1'b1;
        while (cs_n) @(negedge clk);
        win_en = 1'b0;
        wait_txn(5);
        check_txn(4, 6, E_SHORT, "R4");
        check(rec_edges[4] == E_SHORT, "R8", "txn completes after window drop",
              rec_edges[4], E_SHORT);
        repeat (100) @(negedge clk);
        check(txn_cnt == 5, "R7", "no txn after window drop", txn_cnt, 5);

        // variable mode, RWDS high doubles latency; wrap gives done (R4, R6)
        rwds = 1'b1; win_en = 1'b1;
        wait_txn(6);
        win_en = 1'b0;
        check_txn(5, 8, E_LONG, "R4");
        repeat (20) @(negedge clk);
        check(done_n == 2 && done_at[1] == 6, "R6", "done after pass 2",
              done_at[1], 6);
        check(!done_wide, "R6", "done one cycle wide", done_wide, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule